// File: doc/BRIEF.md
# Asynchronous Serial Adapter with Control and Status Registers

This block connects a processor bus to a single asynchronous serial line. The bus reaches two locations, selected by `rs`. Location 0 is the control register when written and the status register when read. Location 1 is the transmit holding register when written and the receive holding register when read. A write to the control register sets four things at once: the ratio between the external bit-clock ticks and the line bit rate, the character framing, the request-to-send level together with transmit interrupt and break, and the receive interrupt enable.

The transmit shifter and the receive shifter both advance only on `bit_tick`. This is a one-cycle enable pulse that a baud source outside the block produces. The bit period is 1, `DIV_MID` or `DIV_HI` ticks. At the two higher ratios the receiver checks a start edge again half a bit later and then samples every following bit at its centre. The interrupt output is active low. Its state also appears in the top bit of the status register.

Top module: `ser_adapter`

## Requirements
- R1: Reset, and any control write with bits [1:0] = 11, put the block into master reset. In that state status bits 0, 1, 4, 5, 6 and 7 read 0, `irq_n` is high and `txd` is high. A transmit-data write made in that state is dropped. Writing a control byte with any other bits [1:0] value leaves master reset, and status bit 1 then reads 1.
- R2: Control bits [1:0] set the number of `bit_tick` pulses in each line bit: 00 gives 1, 01 gives `DIV_MID` (16), and 10 gives `DIV_HI` (64). This holds for both transmit and receive.
- R3: Control bits [4:2] set the framing. Each code is listed as data bits, parity, stop bits: 0 = 7, even, 2; 1 = 7, odd, 2; 2 = 7, even, 1; 3 = 7, odd, 1; 4 = 8, none, 2; 5 = 8, none, 1; 6 = 8, even, 1; 7 = 8, odd, 1. A frame sends a low start bit, then the data least significant bit first, then the parity bit if the format has one, then high stop bits. For 7-bit formats the receive register reads bit 7 as 0.
- R4: The parity bit makes the total count of ones over the data bits and the parity bit even (even parity) or odd (odd parity). A received parity bit that does not match sets status bit 6 when the character is stored.
- R5: A received character whose first stop bit samples low sets status bit 4 (framing error) when the character is stored. Only the first stop bit is checked.
- R6: Control bits [6:5] select the transmit control: 0 gives `rts_n` low with transmit interrupt off; 1 gives `rts_n` low with transmit interrupt on; 2 gives `rts_n` high with transmit interrupt off; 3 gives `rts_n` low with transmit interrupt off.
- R7: While control bits [6:5] = 3 and the block is not in master reset, `txd` is held low.
- R8: The interrupt is active (status bit 7 = 1, `irq_n` low) when control bit 7 is set and receive-full or overrun is set, or when transmit control 1 is selected and transmit-empty is set.
- R9: Status bit 2 follows the `dcd_n` pin level and status bit 3 follows the `cts_n` pin level at all times.
- R10: Reading location 1 clears receive-full (status bit 0) and overrun (status bit 5).
- R11: A character that completes while receive-full is still set sets overrun (status bit 5). The character is discarded and the receive register keeps its previous value.
- R12: A write to location 1 clears transmit-empty (status bit 1) on the next cycle. The byte moves to the shifter on a `bit_tick` while the shifter is idle. Transmit-empty returns to 1 at that point, and the start bit begins on that same tick.
- R13: At ratios 16 and 64 the receiver samples a low start again after half a bit. A line that has returned high by then is treated as noise, and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| rs | input | 1 | Location: 0 control/status, 1 transmit/receive data |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data (status or receive register) |
| bit_tick | input | 1 | One-cycle enable from the external bit clock |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |
| dcd_n | input | 1 | Carrier detect pin, shown in status bit 2 |
| cts_n | input | 1 | Clear-to-send pin, shown in status bit 3 |
| rts_n | output | 1 | Request-to-send pin |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bound checker watches several properties on every cycle. The transmit line may change only on a bit tick or on a control write. A master reset write must silence both the interrupt and the line. A break write must pull the line low. The `rts_n` level must follow the last control write. A data write must clear transmit-empty. A data read must clear the receive flags. A character arriving into a full register must raise overrun and leave the stored byte unchanged. Some behaviour only the bench scenarios can show: the exact bit order, parity and stop count of all eight framings, the tick count of each divide ratio, mid-bit sampling and the rejection of a short start pulse, error flagging, and the point where the interrupt rises and falls.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_e;

    typedef enum logic [1:0] {
        RATE_X1    = 2'd0,
        RATE_MID   = 2'd1,
        RATE_HI    = 2'd2,
        RATE_RESET = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        TXC_RTS_QUIET = 2'd0,
        TXC_RTS_IRQ   = 2'd1,
        TXC_NORTS     = 2'd2,
        TXC_BREAK     = 2'd3
    } txc_e;

    // control byte layout: {rx_irq_en, txc[1:0], fmt[2:0], rate[1:0]}
    typedef struct packed {
        logic        rx_ie;
        txc_e        txc;
        logic [2:0]  fmt;
        rate_e       rate;
    } ctl_t;

    typedef struct packed {
        logic  eight;
        par_e  par;
        logic  two_stop;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [2:0] code);
        frame_fmt_t f;
        case (code)
            3'd0:    f = '{eight: 1'b0, par: PAR_EVEN, two_stop: 1'b1};
            3'd1:    f = '{eight: 1'b0, par: PAR_ODD,  two_stop: 1'b1};
            3'd2:    f = '{eight: 1'b0, par: PAR_EVEN, two_stop: 1'b0};
            3'd3:    f = '{eight: 1'b0, par: PAR_ODD,  two_stop: 1'b0};
            3'd4:    f = '{eight: 1'b1, par: PAR_NONE, two_stop: 1'b1};
            3'd5:    f = '{eight: 1'b1, par: PAR_NONE, two_stop: 1'b0};
            3'd6:    f = '{eight: 1'b1, par: PAR_EVEN, two_stop: 1'b0};
            default: f = '{eight: 1'b1, par: PAR_ODD,  two_stop: 1'b0};
        endcase
        return f;
    endfunction

    function automatic logic [3:0] data_len(input frame_fmt_t f);
        return f.eight ? 4'd8 : 4'd7;
    endfunction

    // start + data + optional parity + stop(s)
    function automatic logic [3:0] frame_len(input frame_fmt_t f);
        logic [3:0] n;
        n = 4'd1 + data_len(f) + ((f.par != PAR_NONE) ? 4'd1 : 4'd0)
            + (f.two_stop ? 4'd2 : 4'd1);
        return n;
    endfunction

    function automatic logic parity_of(input logic [7:0] d, input frame_fmt_t f);
        logic p;
        p = f.eight ? (^d) : (^d[6:0]);
        return (f.par == PAR_ODD) ? ~p : p;
    endfunction

    // serial image, bit 0 goes on the line first; unused tail stays high
    function automatic logic [11:0] make_frame(input logic [7:0] d, input frame_fmt_t f);
        logic [11:0] fr;
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(data_len(f))) fr[i+1] = d[i];
        end
        if (f.par != PAR_NONE) fr[data_len(f) + 4'd1] = parity_of(d, f);
        return fr;
    endfunction

endpackage

// File: rtl/sa_tx.sv
module sa_tx
    import sa_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        tick,
    input  rate_e       rate,
    input  frame_fmt_t  fmt,
    input  logic        brk,
    input  logic        hr_full,
    input  logic [7:0]  hr_data,
    output logic        load,
    output logic        txd
);
    localparam int CNT_W = $clog2(DIV_HI);

    logic [11:0]      shreg;
    logic [3:0]       bits_left;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             busy;

    always_comb begin
        case (rate)
            RATE_MID: limit = CNT_W'(DIV_MID - 1);
            RATE_HI:  limit = CNT_W'(DIV_HI - 1);
            default:  limit = '0;
        endcase
    end

    assign load = tick && !busy && hr_full && !hold;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            cnt       <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            shreg     <= make_frame(hr_data, fmt);
            bits_left <= frame_len(fmt);
            cnt       <= '0;
        end else if (busy && tick) begin
            if (cnt == limit) begin
                cnt       <= '0;
                shreg     <= {1'b1, shreg[11:1]};
                bits_left <= bits_left - 4'd1;
                if (bits_left == 4'd1) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign txd = hold ? 1'b1 : (brk ? 1'b0 : shreg[0]);

endmodule

// File: rtl/sa_rx.sv
module sa_rx
    import sa_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        tick,
    input  rate_e       rate,
    input  frame_fmt_t  fmt,
    input  logic        rxd,
    output logic        done,
    output logic [7:0]  data,
    output logic        ferr,
    output logic        perr
);
    localparam int CNT_W = $clog2(DIV_HI);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

    rx_state_e        state;
    logic [1:0]       sync;
    logic             rxs;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] half;
    logic [3:0]       idx;
    logic [7:0]       dsh;
    logic             pbit;
    logic [7:0]       dmask;

    always_comb begin
        case (rate)
            RATE_MID: begin
                limit = CNT_W'(DIV_MID - 1);
                half  = CNT_W'(DIV_MID / 2 - 1);
            end
            RATE_HI: begin
                limit = CNT_W'(DIV_HI - 1);
                half  = CNT_W'(DIV_HI / 2 - 1);
            end
            default: begin
                limit = '0;
                half  = '0;
            end
        endcase
    end

    assign rxs   = sync[1];
    assign dmask = fmt.eight ? dsh : {1'b0, dsh[6:0]};

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            dsh   <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            data  <= '0;
            ferr  <= 1'b0;
            perr  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxs) begin
                            idx <= '0;
                            dsh <= '0;
                            if (rate == RATE_X1) begin
                                state <= RX_BITS;
                                cnt   <= '0;
                            end else begin
                                state <= RX_START;
                                cnt   <= CNT_W'(1);
                            end
                        end
                    end
                    RX_START: begin
                        if (cnt == half) begin
                            cnt   <= '0;
                            state <= rxs ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == limit) begin
                            cnt <= '0;
                            idx <= idx + 4'd1;
                            if (idx < data_len(fmt)) begin
                                dsh[idx[2:0]] <= rxs;
                            end else if (fmt.par != PAR_NONE && idx == data_len(fmt)) begin
                                pbit <= rxs;
                            end else begin
                                state <= RX_IDLE;
                                done  <= 1'b1;
                                data  <= dmask;
                                ferr  <= !rxs;
                                perr  <= (fmt.par != PAR_NONE) && (pbit != parity_of(dsh, fmt));
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ser_adapter.sv
module ser_adapter
    import sa_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       we,
    input  logic       rs,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       bit_tick,
    input  logic       rxd,
    output logic       txd,
    input  logic       dcd_n,
    input  logic       cts_n,
    output logic       rts_n,
    output logic       irq_n
);
    localparam logic [7:0] CTL_RESET_VAL = 8'h03;

    ctl_t       ctl;
    frame_fmt_t fmt;
    logic       in_rst;
    logic       ctl_wr, data_wr, data_rd;
    logic [7:0] thr;
    logic       thr_full;
    logic [7:0] rhr;
    logic       rdrf, ovrn, fe, pe;
    logic       tdre, irq;
    logic       tx_load;
    logic       rx_done;
    logic [7:0] rx_byte;
    logic       rx_fe, rx_pe;
    logic [7:0] status;

    assign ctl_wr  = cs && we && !rs;
    assign data_wr = cs && we && rs;
    assign data_rd = cs && !we && rs;
    assign in_rst  = (ctl.rate == RATE_RESET);
    assign fmt     = decode_fmt(ctl.fmt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= ctl_t'(CTL_RESET_VAL);
            thr      <= '0;
            thr_full <= 1'b0;
            rhr      <= '0;
            rdrf     <= 1'b0;
            ovrn     <= 1'b0;
            fe       <= 1'b0;
            pe       <= 1'b0;
        end else begin
            if (ctl_wr) ctl <= ctl_t'(wdata);
            if (in_rst) begin
                thr_full <= 1'b0;
                rdrf     <= 1'b0;
                ovrn     <= 1'b0;
                fe       <= 1'b0;
                pe       <= 1'b0;
            end else begin
                if (data_wr) begin
                    thr      <= wdata;
                    thr_full <= 1'b1;
                end else if (tx_load) begin
                    thr_full <= 1'b0;
                end
                if (rx_done) begin
                    if (rdrf && !data_rd) begin
                        ovrn <= 1'b1;
                    end else begin
                        rhr  <= rx_byte;
                        rdrf <= 1'b1;
                        ovrn <= 1'b0;
                        fe   <= rx_fe;
                        pe   <= rx_pe;
                    end
                end else if (data_rd) begin
                    rdrf <= 1'b0;
                    ovrn <= 1'b0;
                end
            end
        end
    end

    sa_tx #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .hold    (in_rst),
        .tick    (bit_tick),
        .rate    (ctl.rate),
        .fmt     (fmt),
        .brk     (ctl.txc == TXC_BREAK),
        .hr_full (thr_full),
        .hr_data (thr),
        .load    (tx_load),
        .txd     (txd)
    );

    sa_rx #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .hold (in_rst),
        .tick (bit_tick),
        .rate (ctl.rate),
        .fmt  (fmt),
        .rxd  (rxd),
        .done (rx_done),
        .data (rx_byte),
        .ferr (rx_fe),
        .perr (rx_pe)
    );

    assign tdre   = !thr_full && !in_rst;
    assign irq    = !in_rst && ((ctl.rx_ie && (rdrf || ovrn)) ||
                                (ctl.txc == TXC_RTS_IRQ && tdre));
    assign status = {irq, pe, ovrn, fe, cts_n, dcd_n, tdre, rdrf};
    assign rdata  = rs ? rhr : status;
    assign rts_n  = (ctl.txc == TXC_NORTS);
    assign irq_n  = !irq;

endmodule

// File: rtl/sa_checker.sv
module sa_checker (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic       data_wr,
    input logic       data_rd,
    input logic [1:0] ctl_rate,
    input logic [1:0] ctl_txc,
    input logic       bit_tick,
    input logic       in_rst,
    input logic       txd,
    input logic       rts_n,
    input logic       irq_n,
    input logic       tdre,
    input logic       rx_done,
    input logic       rdrf,
    input logic       ovrn,
    input logic [7:0] rhr
);

    // R1: a master reset write silences the interrupt and the line
    a_r1_mreset_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_rate == 2'b11) |=> (irq_n && txd));

    // R2: the line only moves on a bit tick or a control write
    a_r2_tick_paced: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !ctl_wr) |=> $stable(txd));

    // R6: rts_n follows the transmit control field
    a_r6_rts_level: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (rts_n == ($past(ctl_txc) == 2'd2)));

    // R7: break code drives the line low
    a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_rate != 2'b11 && ctl_txc == 2'd3) |=> !txd);

    // R10: a data read clears receive-full and overrun
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_done) |=> (!rdrf && !ovrn));

    // R11: a character into a full register flags overrun and is dropped
    a_r11_overrun_keep: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rdrf && !data_rd && !in_rst) |=> (ovrn && $stable(rhr)));

    // R12: a data write empties nothing; transmit-empty drops
    a_r12_write_fills: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !in_rst) |=> !tdre);

endmodule

bind ser_adapter sa_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .ctl_rate (wdata[1:0]),
    .ctl_txc  (wdata[6:5]),
    .bit_tick (bit_tick),
    .in_rst   (in_rst),
    .txd      (txd),
    .rts_n    (rts_n),
    .irq_n    (irq_n),
    .tdre     (tdre),
    .rx_done  (rx_done),
    .rdrf     (rdrf),
    .ovrn     (ovrn),
    .rhr      (rhr)
);

// File: tb/sim_ser_adapter.sv
`timescale 1ns/1ps
module sim_ser_adapter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, we = 1'b0, rs = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       bit_tick;
    logic       rxd = 1'b1;
    logic       txd;
    logic       dcd_n = 1'b1, cts_n = 1'b0;
    logic       rts_n, irq_n;

    int errors = 0;
    int checks = 0;
    logic [1:0] tcnt = '0;

    always #2 clk = ~clk;

    always @(negedge clk) tcnt <= tcnt + 2'd1;
    assign bit_tick = (tcnt == 2'd3);

    ser_adapter u0 (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .rs(rs), .wdata(wdata),
        .rdata(rdata), .bit_tick(bit_tick), .rxd(rxd), .txd(txd),
        .dcd_n(dcd_n), .cts_n(cts_n), .rts_n(rts_n), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!bit_tick) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic loc, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; rs = loc; wdata = v;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic loc, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; rs = loc;
        #1 v = rdata;
        @(negedge clk);
        cs = 1'b0; rs = 1'b0;
    endtask

    function automatic logic [7:0] ctl_byte(input bit rie, input int txc, input int fm, input int rate);
        return {rie, 2'(txc), 3'(fm), 2'(rate)};
    endfunction

    function automatic int dbits(input int fm);  return (fm < 4) ? 7 : 8; endfunction
    function automatic int ptype(input int fm);  // 0 none, 1 even, 2 odd
        if (fm == 4 || fm == 5) return 0;
        if (fm == 0 || fm == 2 || fm == 6) return 1;
        return 2;
    endfunction
    function automatic int nstop(input int fm);  return (fm == 0 || fm == 1 || fm == 4) ? 2 : 1; endfunction
    function automatic int flen(input int fm);
        return 1 + dbits(fm) + ((ptype(fm) != 0) ? 1 : 0) + nstop(fm);
    endfunction
    function automatic int ticks_of(input int rate);
        return (rate == 0) ? 1 : ((rate == 1) ? 16 : 64);
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input int fm);
        logic [11:0] f;
        int ones, pos;
        f = '1;
        f[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < dbits(fm); i++) begin
            f[i+1] = d[i];
            ones += d[i];
        end
        pos = dbits(fm) + 1;
        if (ptype(fm) == 1) f[pos] = (ones % 2 == 1);
        if (ptype(fm) == 2) f[pos] = (ones % 2 == 0);
        return f;
    endfunction

    task automatic tx_frame(input logic [7:0] d, input int fm, input int rate, input string tag);
        logic [11:0] got, exp;
        logic [7:0]  st;
        int waited, n;
        n = ticks_of(rate);
        bus_write(1'b1, d);
        bus_read(1'b0, st);
        // R12: holding register is full right after the write
        check(st[1] == 1'b0, "R12 tdre low after write", st[1], 0);
        waited = 0;
        while (txd !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        got = '1;
        got[0] = txd;
        for (int k = 1; k < flen(fm); k++) begin
            repeat (n) wait_tick();
            got[k] = txd;
        end
        exp = exp_frame(d, fm);
        check(got == exp, tag, got, exp);
        bus_read(1'b0, st);
        check(st[1] == 1'b1, "R12 tdre back after transfer", st[1], 1);
        repeat (n) wait_tick();
    endtask

    task automatic rx_frame(input logic [7:0] d, input int fm, input int rate,
                            input bit bad_par, input bit bad_stop);
        logic [11:0] f;
        int n;
        n = ticks_of(rate);
        f = exp_frame(d, fm);
        if (bad_par) f[dbits(fm) + 1] = ~f[dbits(fm) + 1];
        if (bad_stop) f[dbits(fm) + 1 + ((ptype(fm) != 0) ? 1 : 0)] = 1'b0;
        wait_tick();
        for (int k = 0; k < flen(fm); k++) begin
            rxd = f[k];
            repeat (n) wait_tick();
        end
        rxd = 1'b1;
        repeat (2) wait_tick();
        repeat (3) @(negedge clk);
    endtask

    logic [7:0] st, dv;
    logic [7:0] tx_pat [4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: power-up sits in master reset
        bus_read(1'b0, st);
        check(st == 8'b0000_0100, "R1 status in master reset", st, 8'h04);
        check(txd == 1'b1 && irq_n == 1'b1, "R1 line idle and irq off", {txd, irq_n}, 3);

        // R9: modem pins mirrored
        for (int m = 0; m < 4; m++) begin
            dcd_n = m[0]; cts_n = m[1];
            bus_read(1'b0, st);
            check(st[3:2] == m[1:0], "R9 modem bits", st[3:2], m);
        end
        dcd_n = 1'b0; cts_n = 1'b0;

        bus_write(1'b0, ctl_byte(0, 0, 5, 0));
        bus_read(1'b0, st);
        check(st == 8'h02, "R1 leaving reset shows tdre", st, 8'h02);
        check(rts_n == 1'b0, "R6 rts low for code 0", rts_n, 0);

        // R3 / R4: every format, several bytes, ratio 1
        for (int fm = 0; fm < 8; fm++) begin
            bus_write(1'b0, ctl_byte(0, 0, fm, 0));
            for (int b = 0; b < 4; b++) tx_frame(tx_pat[b], fm, 0, "R3 R4 tx frame");
        end

        // R2: tx at ratios 16 and 64
        bus_write(1'b0, ctl_byte(0, 0, 5, 1));
        tx_frame(8'h96, 5, 1, "R2 tx frame ratio 16");
        bus_write(1'b0, ctl_byte(0, 0, 6, 2));
        tx_frame(8'h4B, 6, 2, "R2 tx frame ratio 64");

        // R3 / R4 / R10: receive every format at ratio 1
        for (int fm = 0; fm < 8; fm++) begin
            bus_write(1'b0, ctl_byte(0, 0, fm, 0));
            for (int b = 0; b < 4; b++) begin
                rx_frame(tx_pat[b] ^ 8'(fm), fm, 0, 0, 0);
                bus_read(1'b0, st);
                check(st[0] == 1 && st[4] == 0 && st[6] == 0, "R3 rx flags clean", st, 1);
                bus_read(1'b1, dv);
                check(dv == ((tx_pat[b] ^ 8'(fm)) & ((fm < 4) ? 8'h7F : 8'hFF)),
                      "R3 rx data", dv, (tx_pat[b] ^ 8'(fm)));
                bus_read(1'b0, st);
                check(st[0] == 0, "R10 read clears rdrf", st[0], 0);
            end
        end

        // R4: parity error
        bus_write(1'b0, ctl_byte(0, 0, 6, 0));
        rx_frame(8'h35, 6, 0, 1, 0);
        bus_read(1'b0, st);
        check(st[6] == 1, "R4 parity error flag", st[6], 1);
        bus_read(1'b1, dv);

        // R5: framing error
        rx_frame(8'h35, 6, 0, 0, 1);
        bus_read(1'b0, st);
        check(st[4] == 1 && st[6] == 0, "R5 framing error flag", st, 8'h11);
        bus_read(1'b1, dv);

        // R11: overrun
        bus_write(1'b0, ctl_byte(0, 0, 5, 0));
        rx_frame(8'h11, 5, 0, 0, 0);
        rx_frame(8'h22, 5, 0, 0, 0);
        bus_read(1'b0, st);
        check(st[5] == 1 && st[0] == 1, "R11 overrun set", st, 8'h21);
        bus_read(1'b1, dv);
        check(dv == 8'h11, "R11 first byte kept", dv, 8'h11);
        bus_read(1'b0, st);
        check(st[5] == 0 && st[0] == 0, "R10 read clears overrun", st, 0);

        // R2 / R13: receive at 16 and 64, with a short glitch first
        bus_write(1'b0, ctl_byte(0, 0, 5, 1));
        wait_tick();
        rxd = 1'b0;
        repeat (4) wait_tick();
        rxd = 1'b1;
        repeat (200) wait_tick();
        bus_read(1'b0, st);
        check(st[0] == 0, "R13 short start rejected", st[0], 0);
        rx_frame(8'hC3, 5, 1, 0, 0);
        bus_read(1'b1, dv);
        check(dv == 8'hC3, "R2 R13 rx ratio 16", dv, 8'hC3);
        bus_write(1'b0, ctl_byte(0, 0, 7, 2));
        rx_frame(8'h5A, 7, 2, 0, 0);
        bus_read(1'b0, st);
        check(st[0] == 1 && st[6] == 0, "R2 rx ratio 64 flags", st, 1);
        bus_read(1'b1, dv);
        check(dv == 8'h5A, "R2 rx ratio 64 data", dv, 8'h5A);

        // R8: receive interrupt
        bus_write(1'b0, ctl_byte(1, 0, 5, 0));
        @(negedge clk);
        check(irq_n == 1'b1, "R8 irq off when empty", irq_n, 1);
        rx_frame(8'h77, 5, 0, 0, 0);
        bus_read(1'b0, st);
        check(irq_n == 1'b0 && st[7] == 1, "R8 rx irq raised", {irq_n, st[7]}, 1);
        bus_read(1'b1, dv);
        @(negedge clk);
        check(irq_n == 1'b1, "R8 rx irq dropped after read", irq_n, 1);

        // R6 / R8: transmit interrupt and rts
        bus_write(1'b0, ctl_byte(0, 1, 5, 0));
        @(negedge clk);
        check(irq_n == 1'b0 && rts_n == 1'b0, "R6 R8 tx irq on, rts low", {irq_n, rts_n}, 0);
        bus_write(1'b0, ctl_byte(0, 2, 5, 0));
        @(negedge clk);
        check(irq_n == 1'b1 && rts_n == 1'b1, "R6 rts high, no irq", {irq_n, rts_n}, 3);

        // R7: break
        bus_write(1'b0, ctl_byte(0, 3, 5, 0));
        repeat (5) wait_tick();
        check(txd == 1'b0 && rts_n == 1'b0 && irq_n == 1'b1, "R7 break holds line low",
              {txd, rts_n, irq_n}, 1);
        bus_write(1'b0, ctl_byte(0, 0, 5, 0));
        @(negedge clk);
        check(txd == 1'b1, "R7 break released", txd, 1);

        // R1: master reset clears flags and drops writes
        rx_frame(8'h0F, 5, 0, 0, 0);
        bus_write(1'b0, ctl_byte(1, 1, 5, 3));
        @(negedge clk);
        bus_read(1'b0, st);
        check((st & 8'hF3) == 8'h00 && irq_n == 1'b1, "R1 master reset clears", st, 0);
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, ctl_byte(0, 0, 5, 0));
        bus_read(1'b0, st);
        check(st[1:0] == 2'b10, "R1 write in reset dropped", st[1:0], 2);
        begin
            bit stayed_high;
            stayed_high = 1'b1;
            repeat (20) begin
                wait_tick();
                if (txd !== 1'b1) stayed_high = 1'b0;
            end
            check(stayed_high, "R1 nothing sent after reset", stayed_high, 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule